// File: doc/BRIEF.md
# Streaming Error-Diffusion Binarizer

This block turns an 8-bit grayscale camera stream into a 1-bit image. The image is packed eight pixels to a byte and written to a frame store through a byte write port. A frame-start strobe opens each frame and a line-start strobe opens each sensor line. Only every other sensor line feeds the image. Within a used line, a fixed number of leading pixels is dropped before the active columns begin.

For each active pixel, the block adds two things to the raw value: the error carried from the pixel to its left, and the error left for this column by the previous used line. It then applies a signed exposure offset with one-sided saturation and compares the result against a fixed threshold. The quantization error is spread to the right neighbour and to three columns of the next used line. That next-line error lives in a buffer one entry per column wide. The block also counts the black pixels of each frame and presents the total of the finished frame.

Top module: `dither_bin`

## Requirements
- R1: A pixel whose adjusted value is below 127 is black and is stored as bit value 1; otherwise it is white and stored as 0.
- R2: The error of a black pixel equals its adjusted value; the error of a white pixel equals its adjusted value minus 255.
- R3: The error is split with signed division by 16 that truncates toward zero. The right neighbour on the same line receives 7/16 of it. On the next used line, the column to the left receives 3/16, the same column 5/16 and the column to the right 1/16. The first pixel of a line receives no error from the left.
- R4: Before thresholding, each pixel is the raw value plus the error carried from the left plus the error stored for its column by the previous used line. All stored errors are zero at the start of every frame.
- R5: The exposure offset `expOffset` is two's complement. A negative offset gives 0 when the sum would fall below 0. A zero or positive offset gives 255 when the sum would rise above 255. Otherwise the offset is added as is.
- R6: The first line-start after a frame-start opens sensor line 0. Only even sensor lines are used, and used line n/2 fills image row n/2. Sensor lines from 2*HEIGHT onward produce no output.
- R7: On each used line, the first LEAD accepted pixels are discarded. The next WIDTH pixels are processed, and any pixels after those are ignored. A pixel presented in a cycle with either strobe high is not accepted.
- R8: The bits are packed first column into bit 7. A byte is issued after its eighth pixel, at address row*WIDTH/8 + column/8.
- R9: `outValid` stays high with `outData` and `outAddr` unchanged until `outReady` is high. `pixReady` is low exactly while a byte is waiting and `outReady` is low.
- R10: On each frame-start, `frameBlack` takes the number of black pixels produced since the previous frame-start, and the running count restarts from zero. `frameBlack` changes at no other time.
- R11: After reset, `outValid` is low, `pixReady` is high and `frameBlack` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle strobe opening a frame |
| lineStart | input | 1 | One-cycle strobe opening a sensor line |
| pixValid | input | 1 | Pixel present on `pixData` |
| pixData | input | 8 | Grayscale pixel value |
| pixReady | output | 1 | Pixel accepted when high together with `pixValid` |
| expOffset | input | OFS_W | Signed exposure offset |
| outValid | output | 1 | Packed byte waiting |
| outReady | input | 1 | Frame store accepts the byte |
| outData | output | 8 | Eight packed pixels, black = 1 |
| outAddr | output | clog2(WIDTH*HEIGHT/8) | Byte address in the frame store |
| frameBlack | output | clog2(WIDTH*HEIGHT+1) | Black pixel total of the last finished frame |

## Verification
A wrong carried error shows up at the first byte of the next used row, because it flips bits there. It then keeps spreading to the right along that row. A wrong left-carry or a wrong offset clamp changes bits within the same byte or the next one, so a per-byte comparison against an independent model finds it within eight pixels. Wrong line or column selection shows up as shifted data, as extra writes or as missing writes, and the write count per frame catches these. A miscounted black total appears at the next frame-start.

// File: rtl/dither_bin_pkg.sv
package dither_bin_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic take;   // process the pixel on pixData this cycle
    logic first;  // it is column 0 of the row
    logic last;   // it is the last column of the row
    logic clear;  // frame boundary: wipe carries, latch the black total
  } dbStrobe_t;
endpackage

// File: rtl/dither_bin_ctrl.sv
module dither_bin_ctrl
  import dither_bin_pkg::*;
#(
  parameter int WIDTH  = 176,
  parameter int HEIGHT = 144,
  parameter int LEAD   = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frameStart,
  input  logic lineStart,
  input  logic pixValid,
  input  logic pixReady,
  output dbStrobe_t strobe,
  output logic [$clog2(WIDTH)-1:0] col,
  output logic [((HEIGHT > 1) ? $clog2(HEIGHT) : 1)-1:0] row
);
  localparam int COL_W = $clog2(WIDTH);
  localparam int ROW_W = (HEIGHT > 1) ? $clog2(HEIGHT) : 1;
  localparam int CNT_W = $clog2(LEAD + WIDTH + 1);
  localparam int LN_W  = $clog2(2 * HEIGHT + 1);
  localparam logic [CNT_W-1:0] CNT_LEAD = CNT_W'(LEAD);
  localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(LEAD + WIDTH);
  localparam logic [LN_W-1:0]  LINE_CAP = LN_W'(2 * HEIGHT);

  logic [LN_W-1:0]  lineNext, lineCur;
  logic [CNT_W-1:0] pixCnt;
  logic             lineOn;
  logic             accept;

  assign accept = pixValid & pixReady & ~frameStart & ~lineStart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lineNext <= '0;
      lineCur  <= '0;
      lineOn   <= 1'b0;
      pixCnt   <= '0;
    end else if (frameStart) begin
      lineNext <= lineStart ? LN_W'(1) : '0;
      lineCur  <= '0;
      lineOn   <= lineStart;
      pixCnt   <= '0;
    end else if (lineStart) begin
      lineCur <= lineNext;
      lineOn  <= ~lineNext[0] && (lineNext < LINE_CAP);
      if (lineNext < LINE_CAP) lineNext <= lineNext + 1'b1;
      pixCnt  <= '0;
    end else if (accept && pixCnt < CNT_CAP) begin
      pixCnt <= pixCnt + 1'b1;
    end
  end

  assign col          = COL_W'(pixCnt - CNT_LEAD);
  assign row          = ROW_W'(lineCur >> 1);
  assign strobe.take  = accept & lineOn & (pixCnt >= CNT_LEAD) & (pixCnt < CNT_CAP);
  assign strobe.first = (col == '0);
  assign strobe.last  = (col == COL_W'(WIDTH - 1));
  assign strobe.clear = frameStart;
endmodule

// File: rtl/dither_bin_dp.sv
module dither_bin_dp
  import dither_bin_pkg::*;
#(
  parameter int WIDTH  = 176,
  parameter int HEIGHT = 144,
  parameter int ERR_W  = 10,
  parameter int OFS_W  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  dbStrobe_t strobe,
  input  logic [$clog2(WIDTH)-1:0] col,
  input  logic [((HEIGHT > 1) ? $clog2(HEIGHT) : 1)-1:0] row,
  input  logic [7:0] pixData,
  input  logic signed [OFS_W-1:0] expOffset,
  input  logic outReady,
  output logic outValid,
  output logic [7:0] outData,
  output logic [$clog2(WIDTH*HEIGHT/8)-1:0] outAddr,
  output logic [$clog2(WIDTH*HEIGHT+1)-1:0] frameBlack
);
  localparam int SW     = ERR_W + 3;
  localparam int MW     = SW + 4;
  localparam int BPL    = WIDTH / 8;
  localparam int ADDR_W = $clog2(WIDTH * HEIGHT / 8);
  localparam int BLK_W  = $clog2(WIDTH * HEIGHT + 1);
  localparam logic signed [SW-1:0] MAXV = SW'(255);
  localparam logic signed [SW-1:0] THR  = SW'(127);

  function automatic logic signed [MW-1:0] div16(input logic signed [MW-1:0] n);
    logic signed [MW-1:0] mag;
    mag = (n < 0) ? -n : n;
    mag = mag >>> 4;
    return (n < 0) ? -mag : mag;
  endfunction

  logic signed [ERR_W-1:0] carryMem [WIDTH];
  logic signed [ERR_W-1:0] accA, accB, aIn, bIn, carryIn, wLeft, newA, newB;
  logic signed [SW-1:0]    xErr, xIn, sum, ofsX, adj, err;
  logic signed [MW-1:0]    errM, d7, d5, d3, d1;
  logic [6:0]              shiftR;
  logic                    isBlack;
  logic [BLK_W-1:0]        runBlack;
  logic [ADDR_W-1:0]       addrNext;

  always_comb begin
    carryIn = carryMem[col];
    xIn     = strobe.first ? '0 : xErr;
    aIn     = strobe.first ? '0 : accA;
    bIn     = strobe.first ? '0 : accB;
    sum     = SW'($signed({1'b0, pixData})) + SW'(carryIn) + xIn;
    ofsX    = SW'(expOffset);
    if (ofsX < 0) adj = (sum < -ofsX) ? '0 : sum + ofsX;
    else          adj = (sum > MAXV - ofsX) ? MAXV : sum + ofsX;
    isBlack = adj < THR;
    err     = isBlack ? adj : adj - MAXV;
    errM    = MW'(err);
    d7      = div16(MW'(errM * 7));
    d5      = div16(MW'(errM * 5));
    d3      = div16(MW'(errM * 3));
    d1      = div16(errM);
    wLeft   = ERR_W'(MW'(aIn) + d3);
    newA    = ERR_W'(MW'(bIn) + d5);
    newB    = ERR_W'(d1);
  end

  assign addrNext = ADDR_W'(row) * ADDR_W'(BPL) + ADDR_W'(col >> 3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < WIDTH; k++) carryMem[k] <= '0;
      accA       <= '0;
      accB       <= '0;
      xErr       <= '0;
      shiftR     <= '0;
      outValid   <= 1'b0;
      outData    <= '0;
      outAddr    <= '0;
      runBlack   <= '0;
      frameBlack <= '0;
    end else begin
      if (outValid && outReady) outValid <= 1'b0;
      if (strobe.clear) begin
        for (int k = 0; k < WIDTH; k++) carryMem[k] <= '0;
        frameBlack <= runBlack;
        runBlack   <= '0;
      end else if (strobe.take) begin
        xErr   <= SW'(d7);
        accA   <= newA;
        accB   <= newB;
        shiftR <= {shiftR[5:0], isBlack};
        if (!strobe.first) carryMem[col - 1'b1] <= wLeft;
        if (strobe.last)   carryMem[col] <= newA;
        if (isBlack) runBlack <= runBlack + 1'b1;
        if (col[2:0] == 3'b111) begin
          outValid <= 1'b1;
          outData  <= {shiftR, isBlack};
          outAddr  <= addrNext;
        end
      end
    end
  end
endmodule

// File: rtl/dither_bin.sv
module dither_bin
  import dither_bin_pkg::*;
#(
  parameter int WIDTH  = 176,
  parameter int HEIGHT = 144,
  parameter int LEAD   = 15,
  parameter int ERR_W  = 10,
  parameter int OFS_W  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frameStart,
  input  logic lineStart,
  input  logic pixValid,
  input  logic [7:0] pixData,
  output logic pixReady,
  input  logic signed [OFS_W-1:0] expOffset,
  output logic outValid,
  input  logic outReady,
  output logic [7:0] outData,
  output logic [$clog2(WIDTH*HEIGHT/8)-1:0] outAddr,
  output logic [$clog2(WIDTH*HEIGHT+1)-1:0] frameBlack
);
  localparam int COL_W = $clog2(WIDTH);
  localparam int ROW_W = (HEIGHT > 1) ? $clog2(HEIGHT) : 1;

  dbStrobe_t        strobe;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;

  assign pixReady = ~(outValid & ~outReady);

  dither_bin_ctrl #(.WIDTH(WIDTH), .HEIGHT(HEIGHT), .LEAD(LEAD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .lineStart(lineStart),
    .pixValid(pixValid), .pixReady(pixReady), .strobe(strobe), .col(col), .row(row)
  );

  dither_bin_dp #(.WIDTH(WIDTH), .HEIGHT(HEIGHT), .ERR_W(ERR_W), .OFS_W(OFS_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .col(col), .row(row),
    .pixData(pixData), .expOffset(expOffset), .outReady(outReady),
    .outValid(outValid), .outData(outData), .outAddr(outAddr), .frameBlack(frameBlack)
  );
endmodule

// File: rtl/dither_bin_chk.sv
module dither_bin_chk #(
  parameter int WIDTH  = 176,
  parameter int HEIGHT = 144
) (
  input logic clk,
  input logic rst_n,
  input logic frameStart,
  input logic lineStart,
  input logic pixReady,
  input logic outValid,
  input logic outReady,
  input logic [7:0] outData,
  input logic [$clog2(WIDTH*HEIGHT/8)-1:0] outAddr,
  input logic [$clog2(WIDTH*HEIGHT+1)-1:0] frameBlack
);
  localparam int NBYTES = WIDTH * HEIGHT / 8;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outAddr)));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |-> !pixReady);

  p_addr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (int'(outAddr) < NBYTES));

  p_total_only_at_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frameStart |=> $stable(frameBlack));

  p_total_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(frameBlack) <= WIDTH * HEIGHT);

  p_strobe_no_pixel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((lineStart || frameStart) && !outValid) |=> !outValid);
endmodule

bind dither_bin dither_bin_chk #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_chk (
  .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .lineStart(lineStart),
  .pixReady(pixReady), .outValid(outValid), .outReady(outReady),
  .outData(outData), .outAddr(outAddr), .frameBlack(frameBlack)
);

// File: tb/dither_bin_bench.sv
module dither_bin_bench;
  localparam int W = 24, H = 3, LEAD = 15, ERR_W = 10, OFS_W = 9;
  localparam int NB = W * H / 8;
  localparam int NPAT = 7;
  // stimulus table: pixel seed (0 = flat 250), exposure offset, ready mode
  localparam int SEED[NPAT] = '{1, 2, 3, 0, 4, 0, 5};
  localparam int OFS[NPAT]  = '{0, 40, -60, 20, 0, -200, 200};
  localparam int RDY[NPAT]  = '{0, 0, 1, 0, 1, 1, 0};

  logic clk = 0, rst_n = 0;
  logic frameStart = 0, lineStart = 0, pixValid = 0, outReady = 1;
  logic [7:0] pixData = 0;
  logic signed [OFS_W-1:0] expOffset = 0;
  logic pixReady, outValid;
  logic [7:0] outData;
  logic [$clog2(NB)-1:0] outAddr;
  logic [$clog2(W*H+1)-1:0] frameBlack;

  int nChk = 0, nFail = 0, readyMode = 0, cyc = 0;
  int nGot = 0, holdViol = 0, stallSeen = 0;
  int got[NB];
  int expB[NB];
  int expBlack;
  logic prevPend = 0;
  logic [7:0] prevData;

  always #4 clk = ~clk;

  dither_bin #(.WIDTH(W), .HEIGHT(H), .LEAD(LEAD), .ERR_W(ERR_W), .OFS_W(OFS_W)) u_dither_bin (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .lineStart(lineStart),
    .pixValid(pixValid), .pixData(pixData), .pixReady(pixReady), .expOffset(expOffset),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outAddr(outAddr),
    .frameBlack(frameBlack)
  );

  always @(posedge clk) begin
    #2;
    cyc = cyc + 1;
    outReady = (readyMode == 0) ? 1'b1 : ((cyc % 5) < 2);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prevPend && (!outValid || outData != prevData)) holdViol++;
      if (outValid && !outReady) stallSeen++;
      if (outValid && outReady) begin
        if (int'(outAddr) < NB) got[outAddr] = int'(outData);
        nGot++;
      end
      prevPend = outValid && !outReady;
      prevData = outData;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pixVal(input int seed, input int line, input int idx);
    if (seed == 0) return 250;
    return (seed * 37 + line * 53 + idx * 29 + idx * idx * seed) & 255;
  endfunction

  // independent model of R1..R8 for one frame
  task automatic buildExp(input int seed, input int ofs);
    int y[W+2];
    int ln[W];
    int x, p, e;
    expBlack = 0;
    for (int k = 0; k < W + 2; k++) y[k] = 0;
    for (int k = 0; k < NB; k++) expB[k] = 0;
    for (int r = 0; r < H; r++) begin
      for (int i = 0; i < W; i++) begin
        ln[i] = pixVal(seed, 2 * r, LEAD + i) + y[i+1];
        y[i+1] = 0;
      end
      x = 0;
      for (int i = 0; i < W; i++) begin
        p = ln[i] + x;
        if (ofs < 0) p = (p < -ofs) ? 0 : p + ofs;
        else         p = (p > 255 - ofs) ? 255 : p + ofs;
        if (p < 127) begin
          e = p;
          expBlack++;
          expB[(r * W + i) / 8] |= (128 >> (i % 8));
        end else e = p - 255;
        x = e * 7 / 16;
        y[i]   += e * 3 / 16;
        y[i+1] += e * 5 / 16;
        y[i+2]  = e / 16;
      end
    end
  endtask

  task automatic strobe(input bit isFrame);
    @(posedge clk); #1;
    if (isFrame) frameStart = 1; else lineStart = 1;
    @(posedge clk); #1;
    frameStart = 0; lineStart = 0;
  endtask

  task automatic sendPix(input int v);
    pixValid = 1; pixData = v[7:0];
    forever begin
      @(negedge clk);
      if (pixReady) break;
    end
    @(posedge clk); #1;
    pixValid = 0;
  endtask

  task automatic runFrame(input int seed, input int ofs, input int mode);
    readyMode = mode;
    expOffset = OFS_W'(ofs);
    for (int k = 0; k < NB; k++) got[k] = -1;
    buildExp(seed, ofs);
    strobe(1);
    nGot = 0;
    for (int ln = 0; ln < 2 * H + 2; ln++) begin
      strobe(0);
      for (int idx = 0; idx < LEAD + W + 3; idx++) begin
        if (idx % 7 == 3) begin @(posedge clk); #1; end
        sendPix(pixVal(seed, ln, idx));
      end
    end
    repeat (20) @(posedge clk);
    for (int k = 0; k < NB; k++)
      chk(got[k] == expB[k], "R1/R2/R3/R4/R5/R8 byte", got[k], expB[k]);
    chk(nGot == NB, "R6/R7 write count", nGot, NB);
    strobe(1);
    @(negedge clk);
    chk(int'(frameBlack) == expBlack, "R10 black total", int'(frameBlack), expBlack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(outValid == 0, "R11 outValid", outValid, 0);
    chk(pixReady == 1, "R11 pixReady", pixReady, 1);
    chk(frameBlack == 0, "R11 frameBlack", int'(frameBlack), 0);
    @(posedge clk); #1; rst_n = 1;

    for (int t = 0; t < NPAT; t++) runFrame(SEED[t], OFS[t], RDY[t]);

    // R9: stalls occurred and held bytes never changed or dropped while waiting
    chk(stallSeen > 0, "R9 stall exercised", stallSeen, 1);
    chk(holdViol == 0, "R9 byte held while waiting", holdViol, 0);

    // R10: an empty frame reports zero black pixels
    strobe(1);
    @(negedge clk);
    chk(frameBlack == 0, "R10 empty frame", int'(frameBlack), 0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule